// File: doc/BRIEF.md
# Shared Platform Timer with Machine and Supervisor Compares

This block is the system-wide wall-clock timer that several harts share. One free-running 64-bit counter advances once per edge of a dedicated real-time clock, so its rate does not follow any core clock. Nothing can stop it, since other harts depend on it. The counter value crosses into the register-bus clock domain as a Gray code through a two-flop synchronizer. Every bus-side consumer sees the same untorn binary value.

For each hart the block holds two 64-bit compare registers on a simple word-wide read/write strobe bus. One is the machine-level compare. The other is the supervisor-level compare, which sits in the shared timer with the same layout. Each compare drives a level-sensitive interrupt line. Each hart also gets a read-only copy of the time value. A virtual-time output adds a per-hart delta to that copy, and a per-hart select lets the supervisor compare be evaluated against virtual time instead of raw time.

Top module: `tmr_platform_timer`

## Requirements
- R1: The counter lives in the `rtc_clk` domain and advances by exactly one on every `rtc_clk` rising edge after `rtc_rst_n` is released. No input can pause it.
- R2: The bus-side time value never decreases. All slices of `hart_time` carry the same value.
- R3: The time value is read-only. Bus writes to byte offsets 0x0 and 0x4 change nothing.
- R4: After reset every compare register reads 0xFFFFFFFF in both words, and all `mtip` and `stip` lines are low.
- R5: `mtip[h]` is the registered result of (time >= machine compare of hart h). It updates one bus clock after the compare or the time changes. It stays high until software writes a larger compare.
- R6: The machine compare of hart h sits at byte offset 0x8+8h (low word) and 0xC+8h (high word). The supervisor compare of hart h uses the same layout starting at 0x8+8N. A supervisor compare drives only `stip[h]`.
- R7: A read of offset 0x0 returns the low time word and latches the high word of that same sample. A read of offset 0x4 returns the latched high word, so a low-then-high pair is coherent.
- R8: `hart_vtime` slice h equals `hart_time` slice h plus `hart_delta` slice h, modulo 2^64.
- R9: When `hart_virt_sel[h]` is 1, `stip[h]` compares virtual time against the supervisor compare. When it is 0, the comparison uses raw time. In both cases the rule is greater-than-or-equal, and the result is registered one bus clock later.
- R10: `bus_rdata` is registered. It is updated on the clock edge where `bus_rd` is high and holds its value otherwise. Unmapped offsets read as zero.
- R11: The counter crosses clock domains as Gray code, with one bit changing per tick. The bus-side time therefore steps by 0 or 1 between consecutive bus clocks when `rtc_clk` is slower than `clk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register-bus clock |
| rst_n | input | 1 | Active-low reset, bus domain |
| rtc_clk | input | 1 | Real-time tick clock for the counter |
| rtc_rst_n | input | 1 | Active-low reset, tick domain |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| hart_delta | input | 64*NUM_HARTS | Per-hart virtual-time delta |
| hart_virt_sel | input | NUM_HARTS | Per-hart select: supervisor compare uses virtual time |
| hart_time | output | 64*NUM_HARTS | Per-hart read-only time copy |
| hart_vtime | output | 64*NUM_HARTS | Per-hart time plus delta |
| mtip | output | NUM_HARTS | Machine timer interrupt per hart |
| stip | output | NUM_HARTS | Supervisor timer interrupt per hart |

## Verification
A synchronizer that lets a torn Gray word through would show as a bus-side time that jumps or runs backwards between two adjacent bus clocks. The bench catches this on the very next sample. A compare register written to the wrong slot or hart raises or drops the wrong interrupt line one bus clock after the write. A comparison against the wrong basis shows on `stip` one clock after the select changes. An error in the counter or the high-word latch shows as a read-back that falls outside the tick count expected for a measured interval.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int TIME_W = 64;
  localparam int WORD_W = 32;

  typedef logic [TIME_W-1:0] time_t;

  // binary to reflected Gray code
  function automatic time_t to_gray(time_t b);
    return b ^ (b >> 1);
  endfunction

  // Gray back to binary: running XOR from the top bit down
  function automatic time_t from_gray(time_t g);
    time_t b;
    b[TIME_W-1] = g[TIME_W-1];
    for (int i = TIME_W-2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // interrupt rule: fire once time has reached the compare value
  function automatic logic reached(time_t t, time_t cmp);
    return t >= cmp;
  endfunction

  // virtual time, wraps modulo 2^TIME_W
  function automatic time_t vtime_add(time_t t, time_t delta);
    return t + delta;
  endfunction
endpackage

// File: rtl/tmr_rtc_count.sv
module tmr_rtc_count
  import tmr_pkg::*;
(
  input  logic  rtc_clk,
  input  logic  rtc_rst_n,
  output time_t gray_o
);
  time_t cnt_q;
  time_t gray_q;
  logic  alive_q;

  always_ff @(posedge rtc_clk or negedge rtc_rst_n) begin
    if (!rtc_rst_n) begin
      cnt_q   <= '0;
      gray_q  <= '0;
      alive_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_q + TIME_W'(1);
      gray_q  <= to_gray(cnt_q + TIME_W'(1));
      alive_q <= 1'b1;
    end
  end

  assign gray_o = gray_q;

  // R1: one step per tick, never held
  p_count_step_r1: assert property (@(posedge rtc_clk) disable iff (!rtc_rst_n)
    alive_q |-> (cnt_q == $past(cnt_q) + TIME_W'(1)));

  // R11: exactly one Gray bit flips per tick
  p_gray_one_bit_r11: assert property (@(posedge rtc_clk) disable iff (!rtc_rst_n)
    alive_q |-> ($countones(gray_q ^ $past(gray_q)) == 1));
endmodule

// File: rtl/tmr_gray_sync.sv
module tmr_gray_sync
  import tmr_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  time_t gray_i,
  output time_t time_o
);
  time_t meta_q;
  time_t safe_q;
  time_t bin_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      safe_q <= '0;
      bin_q  <= '0;
    end else begin
      meta_q <= gray_i;
      safe_q <= meta_q;
      bin_q  <= from_gray(safe_q);
    end
  end

  assign time_o = bin_q;

  // R2: bus-side time never runs backwards
  p_time_mono_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bin_q >= $past(bin_q));
endmodule

// File: rtl/tmr_hart_cmp.sv
module tmr_hart_cmp
  import tmr_pkg::*;
#(
  parameter bit HAS_VIRT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  time_t             time_i,
  input  time_t             delta_i,
  input  logic              virt_sel_i,
  input  logic [3:0]        we_i,      // {s_hi, s_lo, m_hi, m_lo}
  input  logic [WORD_W-1:0] wdata_i,
  output time_t             mcmp_o,
  output time_t             scmp_o,
  output time_t             vtime_o,
  output logic              mtip_o,
  output logic              stip_o
);
  time_t mcmp_q;
  time_t scmp_q;
  time_t s_basis;
  logic  mtip_q;
  logic  stip_q;

  if (HAS_VIRT) begin : g_virt
    assign vtime_o = vtime_add(time_i, delta_i);
    assign s_basis = virt_sel_i ? vtime_o : time_i;
  end else begin : g_plain
    logic unused_virt;
    assign vtime_o     = time_i;
    assign s_basis     = time_i;
    assign unused_virt = ^{delta_i, virt_sel_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mcmp_q <= '1;
      scmp_q <= '1;
      mtip_q <= 1'b0;
      stip_q <= 1'b0;
    end else begin
      if (we_i[0]) mcmp_q[WORD_W-1:0]      <= wdata_i;
      if (we_i[1]) mcmp_q[TIME_W-1:WORD_W] <= wdata_i;
      if (we_i[2]) scmp_q[WORD_W-1:0]      <= wdata_i;
      if (we_i[3]) scmp_q[TIME_W-1:WORD_W] <= wdata_i;
      mtip_q <= reached(time_i, mcmp_q);
      stip_q <= reached(s_basis, scmp_q);
    end
  end

  assign mcmp_o = mcmp_q;
  assign scmp_o = scmp_q;
  assign mtip_o = mtip_q;
  assign stip_o = stip_q;

  // R4: an all-ones machine compare keeps the line quiet
  p_ones_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mcmp_q == '1) |=> !mtip_q);

  // R5: level interrupt holds while its compare is untouched
  p_mtip_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mtip_q && $stable(mcmp_q)) |=> mtip_q);

  // R6/R9: supervisor line holds likewise on raw time
  p_stip_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (stip_q && $stable(scmp_q) && !virt_sel_i && $stable(virt_sel_i)) |=> stip_q);
endmodule

// File: rtl/tmr_platform_timer.sv
module tmr_platform_timer
  import tmr_pkg::*;
#(
  parameter int NUM_HARTS = 2,
  parameter int ADDR_W    = 12,
  parameter bit HAS_VIRT  = 1'b1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        rtc_clk,
  input  logic                        rtc_rst_n,
  input  logic                        bus_wr,
  input  logic                        bus_rd,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic [31:0]                 bus_wdata,
  output logic [31:0]                 bus_rdata,
  input  logic [64*NUM_HARTS-1:0]     hart_delta,
  input  logic [NUM_HARTS-1:0]        hart_virt_sel,
  output logic [64*NUM_HARTS-1:0]     hart_time,
  output logic [64*NUM_HARTS-1:0]     hart_vtime,
  output logic [NUM_HARTS-1:0]        mtip,
  output logic [NUM_HARTS-1:0]        stip
);
  localparam int SLOT_B    = 8;
  localparam int MCMP_BASE = 8;
  localparam int SCMP_BASE = MCMP_BASE + SLOT_B*NUM_HARTS;
  localparam int MAP_END   = SCMP_BASE + SLOT_B*NUM_HARTS;

  function automatic logic [ADDR_W-1:0] slot_addr(int base, int h, bit hi);
    return ADDR_W'(base + SLOT_B*h + (hi ? 4 : 0));
  endfunction

  time_t             gray_w;
  time_t             time_w;
  time_t             mcmp_w [NUM_HARTS];
  time_t             scmp_w [NUM_HARTS];
  logic [WORD_W-1:0] hi_hold_q;
  logic [WORD_W-1:0] rdata_q;
  logic [WORD_W-1:0] rd_val;

  tmr_rtc_count u_count (
    .rtc_clk   (rtc_clk),
    .rtc_rst_n (rtc_rst_n),
    .gray_o    (gray_w)
  );

  tmr_gray_sync u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .gray_i (gray_w),
    .time_o (time_w)
  );

  for (genvar h = 0; h < NUM_HARTS; h++) begin : g_hart
    logic [3:0] we;
    assign we[0] = bus_wr && (bus_addr == slot_addr(MCMP_BASE, h, 1'b0));
    assign we[1] = bus_wr && (bus_addr == slot_addr(MCMP_BASE, h, 1'b1));
    assign we[2] = bus_wr && (bus_addr == slot_addr(SCMP_BASE, h, 1'b0));
    assign we[3] = bus_wr && (bus_addr == slot_addr(SCMP_BASE, h, 1'b1));
    assign hart_time[h*64 +: 64] = time_w;

    tmr_hart_cmp #(.HAS_VIRT(HAS_VIRT)) u_cmp (
      .clk        (clk),
      .rst_n      (rst_n),
      .time_i     (time_w),
      .delta_i    (hart_delta[h*64 +: 64]),
      .virt_sel_i (hart_virt_sel[h]),
      .we_i       (we),
      .wdata_i    (bus_wdata),
      .mcmp_o     (mcmp_w[h]),
      .scmp_o     (scmp_w[h]),
      .vtime_o    (hart_vtime[h*64 +: 64]),
      .mtip_o     (mtip[h]),
      .stip_o     (stip[h])
    );
  end

  always_comb begin
    rd_val = '0;
    if (bus_addr == '0)               rd_val = time_w[WORD_W-1:0];
    else if (bus_addr == ADDR_W'(4))  rd_val = hi_hold_q;
    for (int h = 0; h < NUM_HARTS; h++) begin
      if (bus_addr == slot_addr(MCMP_BASE, h, 1'b0)) rd_val = mcmp_w[h][WORD_W-1:0];
      if (bus_addr == slot_addr(MCMP_BASE, h, 1'b1)) rd_val = mcmp_w[h][TIME_W-1:WORD_W];
      if (bus_addr == slot_addr(SCMP_BASE, h, 1'b0)) rd_val = scmp_w[h][WORD_W-1:0];
      if (bus_addr == slot_addr(SCMP_BASE, h, 1'b1)) rd_val = scmp_w[h][TIME_W-1:WORD_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_hold_q <= '0;
      rdata_q   <= '0;
    end else if (bus_rd) begin
      rdata_q <= rd_val;
      if (bus_addr == '0) hi_hold_q <= time_w[TIME_W-1:WORD_W];
    end
  end

  assign bus_rdata = rdata_q;

  // R7: the high word held is the one sampled with the low read
  p_hold_pair_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == '0) |=> (hi_hold_q == $past(time_w[TIME_W-1:WORD_W])));

  // R10: unmapped offsets read as zero
  p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr >= ADDR_W'(MAP_END)) |=> (bus_rdata == '0));

  // R10: read data holds without a read strobe
  p_rdata_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));
endmodule

// File: tb/tmr_platform_timer_test.sv
module tmr_platform_timer_test;
  localparam int N = 2;
  localparam int AW = 12;
  localparam int SB = 8 + 8*N;   // supervisor compare base

  logic clk = 1'b0, rtc_clk = 1'b0;
  logic rst_n = 1'b0, rtc_rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [64*N-1:0] hart_delta = '0, hart_time, hart_vtime;
  logic [N-1:0] hart_virt_sel = '0, mtip, stip;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;        // 250 MHz bus clock
  always #20 rtc_clk = ~rtc_clk; // slower tick

  tmr_platform_timer #(.NUM_HARTS(N), .ADDR_W(AW), .HAS_VIRT(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .rtc_clk(rtc_clk), .rtc_rst_n(rtc_rst_n),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .hart_delta(hart_delta), .hart_virt_sel(hart_virt_sel),
    .hart_time(hart_time), .hart_vtime(hart_vtime),
    .mtip(mtip), .stip(stip));

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic check_rng(string req, logic [63:0] act, logic [63:0] lo, logic [63:0] hi);
    checks++;
    if (act < lo || act > hi) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h..0x%0h", req, act, lo, hi);
    end
  endtask

  task automatic bus_write(int a, logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic bus_read(int a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = AW'(a);
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R4 mtip after reset", 64'(mtip), 64'd0);
    check("R4 stip after reset", 64'(stip), 64'd0);
    check("R10 rdata after reset", 64'(bus_rdata), 64'd0);
    bus_read(8 + 8*1, d);  check("R4 m compare hart1 low", 64'(d), 64'hFFFF_FFFF);
    bus_read(SB + 4, d);   check("R4 s compare hart0 high", 64'(d), 64'hFFFF_FFFF);
  endtask

  task automatic t_rate();
    logic [31:0] a, b;
    bus_read(0, a);
    repeat (100) @(posedge rtc_clk);
    bus_read(0, b);
    check_rng("R1 ticks over 100 rtc edges", 64'(b - a), 64'd99, 64'd101);
  endtask

  task automatic t_gray_steps();
    logic [63:0] prev, cur;
    bit bad = 1'b0;
    logic [63:0] worst = '0;
    @(negedge clk); prev = hart_time[63:0];
    for (int i = 0; i < 500; i++) begin
      @(negedge clk); cur = hart_time[63:0];
      if (cur < prev || cur - prev > 1) begin bad = 1'b1; worst = cur - prev; end
      prev = cur;
    end
    check("R11 time steps 0 or 1 per bus clock", 64'(bad), 64'd0);
    if (bad) $display("  last bad step 0x%0h", worst);
  endtask

  task automatic t_views();
    logic [63:0] t0;
    hart_delta[63:0] = 64'd5;
    hart_delta[127:64] = '1;
    @(negedge clk);
    t0 = hart_time[63:0];
    check("R2 both harts see same time", hart_time[127:64], t0);
    check("R8 vtime hart0 = time+5", hart_vtime[63:0], t0 + 64'd5);
    check("R8 vtime hart1 wraps to time-1", hart_vtime[127:64], t0 - 64'd1);
    hart_delta = '0;
  endtask

  task automatic t_readonly();
    logic [31:0] d;
    bus_write(0, 32'hFFFF_0000);
    bus_write(4, 32'h1234_5678);
    bus_read(0, d);
    check_rng("R3 low time unaffected by write", 64'(d), 64'd1, 64'h000F_FFFF);
    bus_read(4, d);
    check("R7 R3 latched high word", 64'(d), 64'd0);
  endtask

  task automatic t_mcmp_now();
    bus_write(12, 32'h0);                 // hart0 m high
    @(negedge clk);
    check("R5 compare {0,ones} not reached", 64'(mtip[0]), 64'd0);
    bus_write(8, 32'h0);                  // hart0 m low
    check("R5 mtip not yet at write edge", 64'(mtip[0]), 64'd0);
    @(negedge clk);
    check("R5 mtip one clock after write", 64'(mtip[0]), 64'd1);
    check("R6 other hart untouched", 64'(mtip[1]), 64'd0);
    check("R6 stip untouched by m write", 64'(stip), 64'd0);
    repeat (10) @(negedge clk);
    check("R5 mtip level holds", 64'(mtip[0]), 64'd1);
    bus_write(12, 32'hFFFF_FFFF);
    check("R5 mtip still high at write edge", 64'(mtip[0]), 64'd1);
    @(negedge clk);
    check("R5 mtip clears on larger compare", 64'(mtip[0]), 64'd0);
    bus_write(8, 32'hFFFF_FFFF);
  endtask

  task automatic t_mcmp_future();
    logic [31:0] t;
    bus_read(0, t);
    bus_write(16, t + 32'd300);           // hart1 m low
    bus_write(20, 32'h0);                 // hart1 m high
    repeat (2) @(negedge clk);
    check("R5 future compare not yet reached", 64'(mtip[1]), 64'd0);
    repeat (320) @(posedge rtc_clk);
    repeat (2) @(negedge clk);
    check("R5 future compare reached", 64'(mtip[1]), 64'd1);
    bus_write(20, 32'hFFFF_FFFF);
    bus_write(16, 32'hFFFF_FFFF);
  endtask

  task automatic t_scmp();
    logic [31:0] d;
    bus_write(SB + 12, 32'h0);            // hart1 s high
    bus_write(SB + 8, 32'h0);             // hart1 s low
    @(negedge clk);
    check("R6 stip hart1 via supervisor slot", 64'(stip[1]), 64'd1);
    check("R6 mtip hart1 not driven by s compare", 64'(mtip[1]), 64'd0);
    check("R6 stip hart0 untouched", 64'(stip[0]), 64'd0);
    bus_write(SB + 12, 32'hFFFF_FFFF);
    bus_write(SB + 8, 32'hFFFF_FFFF);
    @(negedge clk);
    check("R6 stip hart1 clears", 64'(stip[1]), 64'd0);
    bus_read(SB + 8, d);
    check("R6 s compare readback", 64'(d), 64'hFFFF_FFFF);
  endtask

  task automatic t_virt();
    hart_delta[63:0] = 64'h1_0000_0000;
    bus_write(SB + 0, 32'h0);             // hart0 s low
    bus_write(SB + 4, 32'h1);             // hart0 s high -> 2^32
    @(negedge clk);
    check("R9 raw time below 2^32", 64'(stip[0]), 64'd0);
    hart_virt_sel[0] = 1'b1;
    @(negedge clk);
    check("R9 virtual time reaches compare", 64'(stip[0]), 64'd1);
    hart_virt_sel[0] = 1'b0;
    @(negedge clk);
    check("R9 back to raw time", 64'(stip[0]), 64'd0);
    hart_delta = '0;
    bus_write(SB + 4, 32'hFFFF_FFFF);
    bus_write(SB + 0, 32'hFFFF_FFFF);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    bus_read(8, d);                       // preload nonzero data
    bus_read(12'h100, d);
    check("R10 unmapped reads zero", 64'(d), 64'd0);
    bus_read(8, d);
    bus_read(2, d);
    check("R10 misaligned reads zero", 64'(d), 64'd0);
    bus_read(8, d);
    repeat (3) @(negedge clk);
    check("R10 rdata held without strobe", 64'(bus_rdata), 64'hFFFF_FFFF);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1; rtc_rst_n = 1'b1;
    t_reset();
    repeat (50) @(negedge clk);
    t_rate();
    t_gray_steps();
    t_views();
    t_readonly();
    t_mcmp_now();
    t_mcmp_future();
    t_scmp();
    t_virt();
    t_unmapped();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule